// File: doc/BRIEF.md
# Program/Erase Status Polling Unit

This block stands in for the self-timed write engine of a byte-wide flash array, together with the status a host sees when it reads during a write. A host hands over one operation at a time: either a byte program, which carries an address and a data byte, or an erase of the whole modelled array. The unit then stays busy for a fixed number of its own clock cycles, chosen separately for program and erase. The host does not pace the operation. While busy, reads do not return array contents. They return a status byte, so software can find completion by polling with no ready pin.

The status byte has two flags. Bit 7 carries the inverse of bit 7 of the byte being programmed, and reads 0 during an erase. Bit 6 flips on every read. Once the operation ends, the array is updated in a single step. A program can only clear bits, so the stored byte becomes the old byte ANDed with the new one. An erase returns every byte to all ones. Reads then give true data, and bit 6 no longer changes.

The start port is a valid/ready handshake. The unit is ready only while idle, and a request offered while busy is simply not taken. A host that keeps `start_valid` high holds its request until the unit is ready. The read port has no back-pressure. A read request is always taken, and its response appears exactly one cycle later; it cannot be stalled.

Top module: `pstat_poll_unit`

## Requirements
- R1: While and after reset, `busy` and `done` are 0, `start_ready` is 1, and every array byte reads 0xFF.
- R2: A start is accepted on a clock edge where `start_valid` and `start_ready` are both 1, and `busy` is 1 in the next cycle. `start_ready` is 0 while busy, and a start offered then has no effect on the running operation or on the array.
- R3: `busy` stays 1 for exactly PROG_CYCLES cycles after a program is accepted (`start_erase`=0), and for ERASE_CYCLES cycles after an erase is accepted (`start_erase`=1).
- R4: `done` is 1 for exactly one cycle: the first cycle in which `busy` is 0 after an operation completes.
- R5: When a program completes, the byte at its address becomes the old byte AND the loaded data. No other byte changes.
- R6: When an erase completes, every byte of the array becomes 0xFF.
- R7: While a program is busy, a read response has bit 7 equal to the inverse of bit 7 of the loaded data, and bits 5..0 equal to 0, at any read address.
- R8: While an erase is busy, a read response has bit 7 and bits 5..0 equal to 0.
- R9: Bit 6 of busy read responses is 1 for the first read after each start, and alternates on each further busy read.
- R10: Every read request (`rd_valid`=1) produces `rd_rvalid`=1 in the next cycle, with no other `rd_rvalid`. When the request was taken while not busy, `rd_data` is the array byte at `rd_addr`.
- R11: Asserting reset during an operation aborts it. `busy` clears, no `done` is produced, and the array returns to all 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start_valid | input | 1 | Operation request valid |
| start_ready | output | 1 | Unit idle and able to take a request |
| start_erase | input | 1 | 1 = erase the array, 0 = program one byte |
| start_addr | input | ADDR_W | Program target address |
| start_data | input | DATA_W | Program data byte |
| rd_valid | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_rvalid | output | 1 | Read response valid, one cycle after request |
| rd_data | output | DATA_W | Array byte, or status byte while busy |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong count in the operation timer shows up on `busy` and `done` within one cycle of the expected end, and the early or late array update can be seen on the next read. A toggle flag that is not cleared at start flips bit 6 on the very first polling response. A wrong operation latch gives a wrong bit 7 on the first busy read, or corrupts the byte read back after completion. The bench drives start and read pulses, including starts while busy and a reset in the middle of an erase, and compares every port against a behavioural model on every cycle.

// File: rtl/pstat_pkg.sv
package pstat_pkg;

  typedef enum logic {
    OP_PROG  = 1'b0,
    OP_ERASE = 1'b1
  } pstat_op_e;

  function automatic int unsigned pstat_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pstat_timer.sv
module pstat_timer #(
  parameter int unsigned PROG_CYCLES  = 16,
  parameter int unsigned ERASE_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic is_erase,
  output logic busy,
  output logic done,
  output logic finish
);
  localparam int unsigned LONGEST = pstat_pkg::pstat_max(PROG_CYCLES, ERASE_CYCLES);
  localparam int unsigned CNT_W   = (LONGEST > 1) ? $clog2(LONGEST) : 1;
  localparam logic [CNT_W-1:0] PROG_LD  = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERASE_LD = CNT_W'(ERASE_CYCLES - 1);

  logic [CNT_W-1:0] remain;

  assign finish = busy && (remain == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      remain <= '0;
    end else begin
      done <= finish;
      if (accept) begin
        busy   <= 1'b1;
        remain <= is_erase ? ERASE_LD : PROG_LD;
      end else if (finish) begin
        busy <= 1'b0;
      end else if (busy) begin
        remain <= remain - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pstat_array.sv
module pstat_array #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_prog,
  input  logic              commit_erase,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_byte
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n || commit_erase) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
    end else if (commit_prog) begin
      cells[wr_addr] <= cells[wr_addr] & wr_data;
    end
  end

  assign rd_byte = cells[rd_addr];
endmodule

// File: rtl/pstat_readout.sv
module pstat_readout #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic              busy,
  input  logic              accept,
  input  logic              poll_msb,
  input  logic [DATA_W-1:0] arr_byte,
  output logic              rd_rvalid,
  output logic [DATA_W-1:0] rd_data
);
  logic toggle;
  logic [DATA_W-1:0] status_byte;

  always_comb begin
    status_byte = '0;
    status_byte[DATA_W-1] = poll_msb;
    status_byte[DATA_W-2] = ~toggle;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_rvalid <= 1'b0;
      rd_data   <= '0;
      toggle    <= 1'b0;
    end else begin
      rd_rvalid <= rd_valid;
      if (accept) begin
        toggle <= 1'b0;
      end else if (rd_valid && busy) begin
        toggle <= ~toggle;
      end
      if (rd_valid) begin
        rd_data <= busy ? status_byte : arr_byte;
      end
    end
  end
endmodule

// File: rtl/pstat_poll_unit.sv
module pstat_poll_unit #(
  parameter int unsigned ADDR_W       = 6,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned PROG_CYCLES  = 16,
  parameter int unsigned ERASE_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic              start_erase,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_data,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_rvalid,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done
);
  import pstat_pkg::*;

  logic              accept;
  logic              finish;
  pstat_op_e         op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] arr_byte;
  logic              poll_msb;

  assign start_ready = ~busy;
  assign accept      = start_valid & start_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= OP_PROG;
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      op_q   <= start_erase ? OP_ERASE : OP_PROG;
      addr_q <= start_addr;
      data_q <= start_data;
    end
  end

  assign poll_msb = (op_q == OP_PROG) ? ~data_q[DATA_W-1] : 1'b0;

  pstat_timer #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .is_erase(start_erase),
    .busy    (busy),
    .done    (done),
    .finish  (finish)
  );

  pstat_array #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_array (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit_prog (finish && (op_q == OP_PROG)),
    .commit_erase(finish && (op_q == OP_ERASE)),
    .wr_addr     (addr_q),
    .wr_data     (data_q),
    .rd_addr     (rd_addr),
    .rd_byte     (arr_byte)
  );

  pstat_readout #(
    .DATA_W(DATA_W)
  ) u_readout (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_valid (rd_valid),
    .busy     (busy),
    .accept   (accept),
    .poll_msb (poll_msb),
    .arr_byte (arr_byte),
    .rd_rvalid(rd_rvalid),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/pstat_poll_unit_chk.sv
module pstat_poll_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic start_valid,
  input logic start_ready,
  input logic rd_valid,
  input logic rd_rvalid,
  input logic busy,
  input logic done
);
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid && start_ready |=> busy); // R2
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_valid)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy)); // R4
  AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rd_rvalid); // R10
  AST_RESP_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rvalid |-> $past(rd_valid)); // R10
endmodule

bind pstat_poll_unit pstat_poll_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_valid(start_valid),
  .start_ready(start_ready),
  .rd_valid   (rd_valid),
  .rd_rvalid  (rd_rvalid),
  .busy       (busy),
  .done       (done)
);

// File: tb/sim_pstat_poll_unit.sv
module sim_pstat_poll_unit;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int PC = 16;
  localparam int EC = 64;

  logic clk = 0;
  logic rst_n = 0;
  logic start_valid = 0, start_erase = 0;
  logic [AW-1:0] start_addr = '0;
  logic [DW-1:0] start_data = '0;
  logic rd_valid = 0;
  logic [AW-1:0] rd_addr = '0;
  logic start_ready, rd_rvalid, busy, done;
  logic [DW-1:0] rd_data;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  bit started = 0;

  always #2 clk = ~clk;

  pstat_poll_unit #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) u0 (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .start_erase(start_erase), .start_addr(start_addr), .start_data(start_data),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_rvalid(rd_rvalid), .rd_data(rd_data),
    .busy(busy), .done(done));

  // behavioural reference model
  int mem [int];
  bit m_busy = 0, m_erase = 0, m_tog = 0, e_done = 0, e_rv = 0, e_poll = 0;
  int m_left = 0, m_addr = 0, m_data = 0, e_rd = 0;
  string ctx = "R1";

  function automatic int rd_mem(int a);
    return mem.exists(a) ? mem[a] : 255;
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      mem.delete();
      m_busy = 0; m_tog = 0; e_done = 0; e_rv = 0;
      ctx = m_busy ? "R11" : ctx;
    end else begin
      e_rv = rd_valid;
      if (rd_valid) begin
        if (m_busy) begin
          m_tog = !m_tog;
          e_poll = 1;
          e_rd = ((m_erase ? 0 : ((~m_data >> 7) & 1)) << 7) | (int'(m_tog) << 6);
        end else begin
          e_poll = 0;
          e_rd = rd_mem(int'(rd_addr));
        end
      end
      e_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0; e_done = 1;
          if (m_erase) begin mem.delete(); ctx = "R6"; end
          else begin mem[m_addr] = rd_mem(m_addr) & m_data; ctx = "R5"; end
        end
      end else if (start_valid) begin
        m_busy = 1; m_erase = start_erase; m_tog = 0;
        m_left = start_erase ? EC : PC;
        m_addr = int'(start_addr); m_data = int'(start_data);
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      chk("R3 busy", int'(busy), int'(m_busy));
      chk("R2 start_ready", int'(start_ready), int'(!m_busy));
      chk("R4 done", int'(done), int'(e_done));
      chk("R10 rd_rvalid", int'(rd_rvalid), int'(e_rv));
      if (rd_rvalid && e_rv) begin
        if (e_poll) begin
          chk("R9 bit6", int'(rd_data[6]), (e_rd >> 6) & 1);
          chk(m_erase ? "R8 status" : "R7 status", int'(rd_data) & 8'hBF, e_rd & 8'hBF);
        end else begin
          chk({ctx, " R10 data"}, int'(rd_data), e_rd);
        end
      end
    end
  end

  task automatic go(bit er, int a, int d);
    @(negedge clk);
    start_valid = 1; start_erase = er; start_addr = AW'(a); start_data = DW'(d);
    @(negedge clk);
    start_valid = 0;
  endtask

  task automatic rd(int a);
    @(negedge clk);
    rd_valid = 1; rd_addr = AW'(a);
    @(negedge clk);
    rd_valid = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset busy", int'(busy), 0);
    rst_n = 1;
    rd(0); rd(63); rd(17);                       // R1 erased contents
    go(0, 5, 8'hA5);                            // program, bit7=1 -> poll bit7=0
    rd(5); rd(9); rd(5);                        // R7 R9
    @(negedge clk); rd_valid = 1; rd_addr = 5;  // back-to-back polling R9
    repeat (3) @(negedge clk);
    rd_valid = 0;
    go(0, 7, 8'h00);                            // R2 start while busy ignored
    wait_idle();
    rd(5); rd(7);                               // R5: A5, 7 untouched FF
    go(0, 5, 8'h3C);                            // 0xA5 & 0x3C = 0x24
    rd(5);
    wait_idle();
    rd(5);
    go(0, 20, 8'h5A);                           // bit7=0 -> poll bit7=1
    rd(20); rd(20);
    wait_idle();
    rd(20);
    // continuous start request held while busy
    @(negedge clk);
    start_valid = 1; start_erase = 0; start_addr = 30; start_data = 8'h0F;
    @(negedge clk); start_data = 8'hF0;         // ignored: already accepted
    wait_idle();
    start_valid = 0;
    @(negedge clk);
    wait_idle();
    rd(30);
    go(1, 0, 0);                                // R8 erase polling
    rd(5); rd(20); rd(30);
    wait_idle();
    rd(5); rd(20); rd(30);                      // R6
    go(0, 3, 8'h11);
    wait_idle();
    go(1, 0, 0);
    repeat (10) @(negedge clk);
    rst_n = 0;                                  // R11 abort mid-erase
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    chk("R11 busy after abort", int'(busy), 0);
    rd(3); rd(5);
    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL R3 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule